// File: doc/BRIEF.md
# Oscillator warm-up delay counter

This block delays a clock-switch or wake-up step until a freshly enabled oscillator has settled. Software picks which oscillator paces the delay (internal fast, external fast or external slow), a power-of-two prescale ratio for that oscillator, and an 8-bit warm-up length. A start pulse then launches the count. Busy stays high for the programmed time, and a one-cycle done pulse marks the end.

The three oscillators reach the block as clock-enable pulses in the system clock domain. The prescaler and the counter run only on those enables, so the whole block sits in one clock domain. The warm-up length is the data value times 2^SHIFT prescaled ticks, with SHIFT = 8 by default. A length of zero is illegal. A start with zero is refused and sets a sticky error flag. A self-clearing abort bit in the control register stops a running count and clears the flag.

Top module: `osc_warmup_timer`

## Requirements
- R1: Writing the control register with bit 4 = 1 has these effects in the next cycle: busy = 0, err = 0, and no done pulse. A count started again afterwards runs its full length.
- R2: Control bit 4 is never stored, so it always reads back as 0. The same write still updates the source and divide fields.
- R3: Control register layout:
  - bits 1:0 select the source: 00 internal fast, 01 external fast, 10 external slow, 11 reserved.
  - bits 3:2 select the divide ratio: 00 /1, 01 /2, 10 /4, 11 /8.
  - bits 7:4 always read as 0.
  - The control register is address 0 and the data register is address 1. Both reads are combinational.
- R4: The data register at address 1 reads back the 8-bit value last written to it.
- R5: A start while idle with a nonzero data value D raises busy from the next cycle. Busy stays high until D·2^SHIFT prescaled ticks have occurred.
- R6: The last tick drops busy and raises done for exactly one cycle, both on the same clock edge.
- R7: With divide code k, one prescaled tick occurs for every 2^k enable pulses of the selected source seen while busy. A whole count therefore takes D·2^SHIFT·2^k source pulses.
- R8: A start while idle with data = 0 leaves busy low and sets err. Err stays set, even through later legal data writes, until an abort write (R1).
- R9: With source code 11, busy stays high and done never comes until an abort write.
- R10: A start pulse while busy is ignored. The running count neither restarts nor stretches.
- R11: After reset: busy, done and err are 0, and both registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 data |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 data |
| rd_data | output | 8 | Read data (combinational) |
| ce_int_hi | input | 1 | Enable pulse of the internal fast oscillator |
| ce_ext_hi | input | 1 | Enable pulse of the external fast oscillator |
| ce_ext_lo | input | 1 | Enable pulse of the external slow oscillator |
| start | input | 1 | Start-count pulse |
| busy | output | 1 | Warm-up in progress |
| done | output | 1 | One-cycle end-of-warm-up pulse |
| err | output | 1 | Sticky flag: a start was refused because data was 0 |

## Verification
Different internal faults show up at the ports in different ways:
- A wrong prescaler mask or a wrong source select changes how many enable pulses of the chosen oscillator occur while busy is high. This only becomes visible when done arrives, so the bench counts those pulses exactly over whole counts.
- A wrong terminal compare shifts done by whole prescaled ticks.
- An abort or error-flag fault is visible on busy and err one cycle after the write.
- A reserved-source fault shows as a done pulse hundreds of cycles later, so the frozen case is watched over a long window.

// File: rtl/owu_pkg.sv
package owu_pkg;

  typedef enum logic [1:0] {
    SRC_INT_HI = 2'b00,
    SRC_EXT_HI = 2'b01,
    SRC_EXT_LO = 2'b10,
    SRC_NONE   = 2'b11
  } owu_src_e;

  typedef struct packed {
    logic [1:0] div;
    owu_src_e   src;
  } owu_cfg_t;

  localparam int OWU_ABORT_BIT = 4;
  localparam int OWU_NUM_SRC   = 3;

endpackage

// File: rtl/owu_regs.sv
module owu_regs
  import owu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_addr,
  output logic [7:0]        rd_data,
  output owu_cfg_t          cfg,
  output logic [DATA_W-1:0] data_val,
  output logic              abort
);

  owu_cfg_t          cfg_q, cfg_n;
  logic [DATA_W-1:0] data_q, data_n;

  // Abort is a write-side strobe only; nothing is stored, so it reads as 0.
  assign abort = wr_en && !wr_addr && wr_data[OWU_ABORT_BIT];

  always_comb begin
    cfg_n  = cfg_q;
    data_n = data_q;
    if (wr_en) begin
      if (!wr_addr) cfg_n = owu_cfg_t'(wr_data[3:0]);
      else          data_n = wr_data[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      data_q <= '0;
    end else begin
      cfg_q  <= cfg_n;
      data_q <= data_n;
    end
  end

  always_comb begin
    if (!rd_addr) rd_data = {4'b0000, cfg_q};
    else          rd_data = 8'(data_q);
  end

  assign cfg      = cfg_q;
  assign data_val = data_q;

endmodule

// File: rtl/owu_prescale.sv
module owu_prescale
  import owu_pkg::*;
#(
  parameter int PRE_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restart,
  input  logic                   run,
  input  logic [OWU_NUM_SRC-1:0] src_ce,
  input  owu_cfg_t               cfg,
  output logic                   tick
);

  localparam int NUM_DIV = 4;

  logic [PRE_W-1:0] mask_tbl [NUM_DIV];
  logic [3:0]       ce_all;
  logic             sel_ce;
  logic [PRE_W-1:0] pre_q, pre_n, mask;

  genvar g;
  generate
    for (g = 0; g < NUM_DIV; g++) begin : g_mask
      assign mask_tbl[g] = PRE_W'((1 << g) - 1);
    end
  endgenerate

  // Reserved source code selects a constant 0: no tick ever.
  assign ce_all = {1'b0, src_ce};
  assign sel_ce = ce_all[cfg.src];
  assign mask   = mask_tbl[cfg.div];
  assign tick   = run && sel_ce && ((pre_q & mask) == mask);

  always_comb begin
    pre_n = pre_q;
    if (restart)             pre_n = '0;
    else if (run && sel_ce)  pre_n = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_n;
  end

endmodule

// File: rtl/owu_count.sv
module owu_count #(
  parameter int DATA_W = 8,
  parameter int SHIFT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic              tick,
  input  logic [DATA_W-1:0] data_val,
  output logic              restart,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int CNT_W = DATA_W + SHIFT;

  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_inc, target;
  logic             busy_q, busy_n, done_q, done_n, err_q, err_n;
  logic             accept;

  assign target  = {data_val, {SHIFT{1'b0}}};
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign accept  = !abort && !busy_q && start && (data_val != '0);
  assign restart = abort || accept;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    err_n  = err_q;
    done_n = 1'b0;
    if (abort) begin
      busy_n = 1'b0;
      cnt_n  = '0;
      err_n  = 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        if (data_val == '0) err_n = 1'b1;
        else begin
          busy_n = 1'b1;
          cnt_n  = '0;
        end
      end
    end else if (tick) begin
      if (cnt_inc == target) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;

endmodule

// File: rtl/osc_warmup_timer.sv
module osc_warmup_timer
  import owu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SHIFT  = 8,
  parameter int PRE_W  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_addr,
  output logic [7:0] rd_data,
  input  logic       ce_int_hi,
  input  logic       ce_ext_hi,
  input  logic       ce_ext_lo,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic       err
);

  owu_cfg_t          cfg;
  logic [DATA_W-1:0] data_val;
  logic              abort, restart, tick;
  logic [1:0]        cfg_src;

  assign cfg_src = cfg.src;

  owu_regs #(.DATA_W(DATA_W)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cfg      (cfg),
    .data_val (data_val),
    .abort    (abort)
  );

  owu_prescale #(.PRE_W(PRE_W)) i_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (busy),
    .src_ce  ({ce_ext_lo, ce_ext_hi, ce_int_hi}),
    .cfg     (cfg),
    .tick    (tick)
  );

  owu_count #(.DATA_W(DATA_W), .SHIFT(SHIFT)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (abort),
    .start    (start),
    .tick     (tick),
    .data_val (data_val),
    .restart  (restart),
    .busy     (busy),
    .done     (done),
    .err      (err)
  );

endmodule

// File: rtl/owu_checker.sv
module owu_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              abort,
  input logic [1:0]        cfg_src,
  input logic [DATA_W-1:0] data_val,
  input logic              rd_addr,
  input logic [7:0]        rd_data
);

  AST_ABORT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !err && !done)); // R1

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_addr |-> (rd_data[7:4] == 4'b0000)); // R3

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !abort && data_val != '0) |=> busy); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R6

  AST_ZERO_START_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !abort && data_val == '0) |=> (err && !busy)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !abort) |=> err); // R8

  AST_RSVD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_src == 2'b11 && !abort) |=> (busy && !done)); // R9

endmodule

bind osc_warmup_timer owu_checker #(.DATA_W(DATA_W)) i_owu_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .abort    (abort),
  .cfg_src  (cfg_src),
  .data_val (data_val),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data)
);

// File: tb/test_osc_warmup_timer.sv
module test_osc_warmup_timer;

  logic       clk, rst_n;
  logic       wr_en, wr_addr, rd_addr, start;
  logic [7:0] wr_data, rd_data;
  logic       ce_int_hi, ce_ext_hi, ce_ext_lo;
  logic       busy, done, err;
  logic [3:0] phase;

  int n_total = 0;
  int n_bad   = 0;

  osc_warmup_timer i_osc_warmup_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ce_int_hi(ce_int_hi), .ce_ext_hi(ce_ext_hi), .ce_ext_lo(ce_ext_lo),
    .start(start), .busy(busy), .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // Oscillator enables: fast internal always on, fast external every 2nd cycle,
  // slow external every 5th cycle. Updated at posedge, stable at negedge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase <= 4'd0;
    else if (phase == 4'd9) phase <= 4'd0;
    else                   phase <= phase + 4'd1;
  end
  assign ce_int_hi = 1'b1;
  assign ce_ext_hi = phase[0];
  assign ce_ext_lo = (phase == 4'd2) || (phase == 4'd7);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input bit addr, input logic [7:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input bit addr, output logic [7:0] val);
    rd_addr = addr;
    #1 val = rd_data;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic sel_ce(input logic [1:0] s);
    case (s)
      2'b00:   return ce_int_hi;
      2'b01:   return ce_ext_hi;
      2'b10:   return ce_ext_lo;
      default: return 1'b0;
    endcase
  endfunction

  // Run one full count; count source pulses seen while busy; re-pulse start
  // at cycle restart_at (0 = never).
  task automatic run_period(input logic [1:0] s, input logic [1:0] dv,
                            input logic [7:0] d, input int restart_at, input string req);
    int pulses = 0;
    int cyc = 0;
    int exp = int'(d) * 256 * (1 << dv);
    bit saw_done = 0;
    reg_write(1'b0, {4'b0000, dv, s});
    reg_write(1'b1, d);
    pulse_start();
    check(busy === 1'b1, {req, " busy after start"}, busy, 1);
    while (cyc < 150000) begin
      if (done === 1'b1) begin saw_done = 1; break; end
      if (busy && sel_ce(s)) pulses++;
      if (restart_at != 0 && cyc == restart_at) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(saw_done, {req, " done seen"}, saw_done, 1);
    check(pulses == exp, {req, " source pulses while busy"}, pulses, exp);
    check(busy === 1'b0, {req, " busy low with done"}, busy, 0);  // R6
    @(negedge clk);
    check(done === 1'b0, {req, " R6 done one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R11 outputs", {busy, done, err}, 0);
    reg_read(1'b0, v); check(v === 8'h00, "R11 ctrl", v, 0);
    reg_read(1'b1, v); check(v === 8'h00, "R11 data", v, 0);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    reg_write(1'b0, 8'hFE);
    reg_read(1'b0, v); check(v === 8'h0E, "R3 upper bits zero, R2 abort bit reads 0", v, 8'h0E);
    reg_write(1'b1, 8'hA5);
    reg_read(1'b1, v); check(v === 8'hA5, "R4 data readback", v, 8'hA5);
  endtask

  task automatic t_zero_start();
    reg_write(1'b0, 8'h10);
    reg_write(1'b1, 8'h00);
    pulse_start();
    check(busy === 1'b0, "R8 zero start ignored", busy, 0);
    check(err === 1'b1, "R8 err set", err, 1);
    reg_write(1'b1, 8'h05);
    repeat (3) @(negedge clk);
    check(err === 1'b1, "R8 err sticky", err, 1);
    reg_write(1'b0, 8'h10);
    check(err === 1'b0, "R8 R1 abort clears err", err, 0);
  endtask

  task automatic t_abort();
    int d_seen = 0;
    reg_write(1'b0, 8'h00);
    reg_write(1'b1, 8'h01);
    pulse_start();
    repeat (20) @(negedge clk);
    reg_write(1'b0, 8'h10);
    check(busy === 1'b0, "R1 abort stops count", busy, 0);
    for (int i = 0; i < 400; i++) begin
      if (done) d_seen++;
      @(negedge clk);
    end
    check(d_seen == 0, "R1 no done after abort", d_seen, 0);
    run_period(2'b00, 2'b00, 8'h01, 0, "R1 full count after abort");
  endtask

  task automatic t_reserved();
    int d_seen = 0;
    reg_write(1'b0, 8'h03);
    reg_write(1'b1, 8'h01);
    pulse_start();
    for (int i = 0; i < 1500; i++) begin
      if (done) d_seen++;
      @(negedge clk);
    end
    check(busy === 1'b1 && d_seen == 0, "R9 reserved source frozen", {busy, 1'(d_seen != 0)}, 2);
    reg_write(1'b0, 8'h13);
    check(busy === 1'b0, "R9 abort releases reserved", busy, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_total++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
    rd_addr = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_zero_start();
    run_period(2'b00, 2'b00, 8'h01, 0,   "R5 internal fast /1 D=1");
    run_period(2'b01, 2'b01, 8'h03, 0,   "R7 external fast /2 D=3");
    run_period(2'b10, 2'b11, 8'h01, 0,   "R7 external slow /8 D=1");
    run_period(2'b00, 2'b10, 8'h02, 0,   "R7 internal fast /4 D=2");
    run_period(2'b00, 2'b00, 8'hFF, 0,   "R5 max data D=255");
    run_period(2'b00, 2'b00, 8'h01, 100, "R10 start while busy ignored");
    t_abort();
    t_reserved();
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule